// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order in which column addresses are visited during one read or write burst of a double-data-rate memory device. A command path presents a starting column, a four-bit mode word and a one-cycle start strobe. The sequencer then emits one column address per clock, one beat at a time, until the burst is complete, and marks the opening and closing beats so that downstream data-path logic can frame the transfer.

The mode word selects a burst of four or eight beats and one of two visiting orders. The sequential order counts upward through the low column bits and wraps inside the naturally aligned block of the burst size. The interleaved order gives each beat the start column XOR the beat index. Column bits above the burst field travel through untouched. A reserved length code is flagged and produces no beats, and an active burst can be cut short with a terminate input.

Top module: `burst_col_seq`

## Requirements
- R1: Length code mode_in[2:0] = 3'b010 gives a burst of exactly 4 beats and 3'b011 gives exactly 8 beats; beat 0 is presented (valid high) in the clock cycle after the edge that accepts start, and one new beat follows on each later cycle.
- R2: With mode_in[3] = 0 the order is sequential: beat k carries the low burst field equal to (start + k) modulo the burst length, so an 8-beat burst from 5 visits 5,6,7,0,1,2,3,4.
- R3: With mode_in[3] = 1 the order is interleaved: beat k carries start XOR k in the burst field, so an 8-beat burst from 5 visits 5,4,7,6,1,0,3,2.
- R4: A 4-beat burst reorders only col bits [1:0] and holds col bit 2 at its start value on every beat; an 8-beat burst reorders col bits [2:0].
- R5: Column bits above bit 2 equal the start column's bits on every beat of a burst.
- R6: A start accepted with any length code other than 3'b010 or 3'b011 raises err for exactly one cycle (the cycle after the accepting edge) and produces no beat: valid stays low.
- R7: A start strobe while valid is high is ignored: the running burst continues with its own addresses and flags unchanged.
- R8: Asserting term while valid is high ends the burst: valid is low in the next cycle, and a later start is accepted normally.
- R9: first is high only on beat 0, last is high only on the final beat, and valid is low in the cycle after the final beat.
- R10: During and just after reset valid, first, last and err are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled when no burst is running |
| term | input | 1 | Ends the running burst at the next edge |
| col_in | input | COL_W | Starting column address |
| mode_in | input | 4 | [2:0] length code, [3] order select |
| col_out | output | COL_W | Column address of the current beat |
| valid | output | 1 | A beat is presented this cycle |
| first | output | 1 | Current beat is beat 0 |
| last | output | 1 | Current beat is the final beat |
| err | output | 1 | One-cycle pulse for a reserved length code |

## Verification
The embedded properties watch every cycle for the framing rules: a final beat or a terminate is always followed by an idle cycle, a running burst steps its beat index by one, first never reappears mid-burst (which is how an ignored start shows), upper column bits hold still, and err never coincides with a beat. The actual address values of each ordering, the exact beat counts for each length code, the field width used for a 4-beat versus an 8-beat burst, and the recovery after a terminate are only shown by the bench's directed scenarios, which compare each beat against values computed from the ordering rules.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   // widest burst field: an 8-beat burst reorders three column bits
   localparam int unsigned BFLD_W  = 3;
   localparam int unsigned MODE_W  = 4;
   localparam int unsigned LLOG_W  = 2;

   localparam logic [2:0] LEN_CODE_BL4 = 3'b010;
   localparam logic [2:0] LEN_CODE_BL8 = 3'b011;

   typedef enum logic {
      ORD_SEQ  = 1'b0,
      ORD_INTL = 1'b1
   } order_e;

   typedef struct packed {
      logic              ok;
      logic [LLOG_W-1:0] len_log;
      order_e            order;
   } mode_t;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
   import burst_col_pkg::*;
(
   input  logic [MODE_W-1:0] mode_in,
   output mode_t             dec
);

   always_comb begin
      dec.order = order_e'(mode_in[3]);
      case (mode_in[2:0])
         LEN_CODE_BL4: begin
            dec.ok      = 1'b1;
            dec.len_log = 2'd2;
         end
         LEN_CODE_BL8: begin
            dec.ok      = 1'b1;
            dec.len_log = 2'd3;
         end
         default: begin
            dec.ok      = 1'b0;
            dec.len_log = 2'd0;
         end
      endcase
   end

   // R1: an accepted code always names a length the counter can reach
   always_comb begin
      if (dec.ok) begin
         a_r1_len_range: assert (dec.len_log >= 2'd2 && int'(dec.len_log) <= int'(BFLD_W));
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_col_pkg::*;
#(
   parameter int unsigned CNT_W = BFLD_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              term,
   input  logic [LLOG_W-1:0] len_log_in,
   output logic              busy,
   output logic [CNT_W-1:0]  beat,
   output logic [LLOG_W-1:0] len_log,
   output logic              first_beat,
   output logic              last_beat
);

   logic [CNT_W-1:0] end_beat;

   assign end_beat   = CNT_W'((32'd1 << len_log) - 32'd1);
   assign first_beat = busy && (beat == '0);
   assign last_beat  = busy && (beat == end_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         beat    <= '0;
         len_log <= '0;
      end else if (busy) begin
         if (term || last_beat) begin
            busy <= 1'b0;
            beat <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end else if (load) begin
         busy    <= 1'b1;
         beat    <= '0;
         len_log <= len_log_in;
      end
   end

   // R9: the final beat is always followed by an idle cycle
   a_r9_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |=> !busy);

   // R8: terminate closes a running burst at the next edge
   a_r8_term_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && term) |=> !busy);

   // R1: a running burst advances exactly one beat per cycle
   a_r1_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_beat && !term) |=> (busy && beat == $past(beat) + 1'b1));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 10
)(
   input  logic [COL_W-1:0]  base,
   input  logic [BFLD_W-1:0] beat,
   input  logic [LLOG_W-1:0] len_log,
   input  order_e            order,
   output logic [COL_W-1:0]  col
);

   localparam int unsigned HI_W = COL_W - BFLD_W;

   logic [BFLD_W-1:0] wrap_sum;
   logic [BFLD_W-1:0] xor_val;

   assign wrap_sum = base[BFLD_W-1:0] + beat;
   assign xor_val  = base[BFLD_W-1:0] ^ beat;

   // per-bit choice: inside the burst field take the ordering, outside keep the start bit
   for (genvar i = 0; i < int'(BFLD_W); i++) begin : g_fld
      logic in_field;
      assign in_field = (int'(len_log) > i);
      always_comb begin
         if (!in_field)
            col[i] = base[i];
         else if (order == ORD_INTL)
            col[i] = xor_val[i];
         else
            col[i] = wrap_sum[i];
      end
   end

   if (HI_W > 0) begin : g_hi
      assign col[COL_W-1:BFLD_W] = base[COL_W-1:BFLD_W];
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              term,
   input  logic [COL_W-1:0]  col_in,
   input  logic [MODE_W-1:0] mode_in,
   output logic [COL_W-1:0]  col_out,
   output logic              valid,
   output logic              first,
   output logic              last,
   output logic              err
);

   if (COL_W < BFLD_W) begin : g_bad_width
      $error("burst_col_seq: COL_W must cover the burst field");
   end

   mode_t             dec;
   logic              busy;
   logic              accept;
   logic              load;
   logic [BFLD_W-1:0] beat;
   logic [LLOG_W-1:0] len_log;
   logic [COL_W-1:0]  base_q;
   order_e            order_q;
   logic              err_q;

   burst_mode_dec u_dec (
      .mode_in (mode_in),
      .dec     (dec)
   );

   assign accept = start && !busy;
   assign load   = accept && dec.ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_SEQ;
         err_q   <= 1'b0;
      end else begin
         err_q <= accept && !dec.ok;
         if (load) begin
            base_q  <= col_in;
            order_q <= dec.order;
         end
      end
   end

   burst_beat_ctr #(.CNT_W(BFLD_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .term       (term),
      .len_log_in (dec.len_log),
      .busy       (busy),
      .beat       (beat),
      .len_log    (len_log),
      .first_beat (first),
      .last_beat  (last)
   );

   burst_addr_gen #(.COL_W(COL_W)) u_addr (
      .base    (base_q),
      .beat    (beat),
      .len_log (len_log),
      .order   (order_q),
      .col     (col_out)
   );

   assign valid = busy;
   assign err   = err_q;

   // R6: a reserved code never coincides with a beat
   a_r6_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !valid);

   // R7: a start during a running burst does not restart it
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !last && !term) |=> !first);

   // R9: the framing flags only appear with a beat
   a_r9_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (first || last) |-> valid);

   // R1: every burst opens with its first beat
   a_r1_open_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> first);

   if (COL_W > BFLD_W) begin : g_hi_chk
      // R5: upper column bits hold still across a burst
      a_r5_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && !last && !term) |=>
            (col_out[COL_W-1:BFLD_W] == $past(col_out[COL_W-1:BFLD_W])));
   end

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;

   localparam int CLK_P = 10;
   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             term = 1'b0;
   logic [COL_W-1:0] col_in = '0;
   logic [3:0]       mode_in = '0;
   logic [COL_W-1:0] col_out;
   logic             valid, first, last, err;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .term(term),
      .col_in(col_in), .mode_in(mode_in),
      .col_out(col_out), .valid(valid), .first(first), .last(last), .err(err)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected column from the ordering rules
   function automatic int exp_col(input int base, input int k, input int bl, input bit intl);
      if (intl) return base ^ k;
      return (base & ~(bl - 1)) | ((base + k) & (bl - 1));
   endfunction

   // drives one burst and checks every beat and the idle cycle after it
   task automatic run_burst(input int base, input int bl, input bit intl, input string req);
      start   = 1'b1;
      col_in  = COL_W'(base);
      mode_in = {intl, (bl == 8) ? 3'b011 : 3'b010};
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < bl; k++) begin
         chk({req, " valid"}, int'(valid), 1);
         chk({req, " col"},   int'(col_out), exp_col(base, k, bl, intl));
         chk({req, " R9 first"}, int'(first), (k == 0) ? 1 : 0);
         chk({req, " R9 last"},  int'(last), (k == bl - 1) ? 1 : 0);
         @(negedge clk);
      end
      chk({req, " R9 idle after last"}, int'(valid), 0);
   endtask

   task automatic t_reset;
      chk("R10 valid", int'(valid), 0);
      chk("R10 first", int'(first), 0);
      chk("R10 last",  int'(last), 0);
      chk("R10 err",   int'(err), 0);
   endtask

   task automatic t_seq8;
      run_burst(5, 8, 1'b0, "R2 seq8 from5");
      run_burst(10'h3F8, 8, 1'b0, "R2 seq8 aligned");
   endtask

   task automatic t_intl8;
      run_burst(5, 8, 1'b1, "R3 intl8 from5");
      run_burst(10'h2A3, 8, 1'b1, "R3 R5 intl8 upper");
   endtask

   task automatic t_bl4;
      // bit 2 set in the start column must stay set: R4
      run_burst(10'h3A6, 4, 1'b0, "R4 R1 seq4 bit2");
      run_burst(10'h12D, 4, 1'b1, "R4 R1 intl4 bit2");
      run_burst(10'h155, 4, 1'b0, "R4 R5 seq4 wrap");
   endtask

   task automatic t_reserved;
      for (int c = 0; c < 8; c++) begin
         if (c == 2 || c == 3) continue;
         start   = 1'b1;
         col_in  = 10'h011;
         mode_in = {1'b0, 3'(c)};
         @(negedge clk);
         start = 1'b0;
         chk("R6 err pulse", int'(err), 1);
         chk("R6 no beat", int'(valid), 0);
         @(negedge clk);
         chk("R6 err single", int'(err), 0);
         chk("R6 still idle", int'(valid), 0);
      end
   endtask

   task automatic t_start_ignored;
      int base = 10'h0C6;
      start   = 1'b1;
      col_in  = COL_W'(base);
      mode_in = 4'b0011;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R7 col", int'(col_out), exp_col(base, k, 8, 1'b0));
         chk("R7 first", int'(first), (k == 0) ? 1 : 0);
         if (k == 2 || k == 5) begin
            start   = 1'b1;
            col_in  = 10'h301;
            mode_in = 4'b1010;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R7 ends on schedule", int'(valid), 0);
   endtask

   task automatic t_term;
      start   = 1'b1;
      col_in  = 10'h044;
      mode_in = 4'b1011;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8 running before term", int'(valid), 1);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R8 stopped", int'(valid), 0);
      chk("R8 no last", int'(last), 0);
      run_burst(10'h07B, 4, 1'b0, "R8 restart after term");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seq8();
      t_intl8();
      t_bl4();
      t_reserved();
      t_start_ignored();
      t_term();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule